// File: doc/BRIEF.md
# Cache Power and Invalidation Controller

This block owns the control and status registers of a small cache when software runs SRAM power and tag invalidation by hand. A write to the control register can select the manual modes, raise or drop the power request toward the SRAM power switch, start an invalidation sweep, and turn the cache on. The status register reports whether the SRAMs are powered and whether the cache is still active.

The power switch is reached through a request/acknowledge pair. Power status becomes 1 only after the switch acknowledges. An invalidation walks every tag line, one per clock, and drives a valid-clear strobe and a line index toward the tag RAM. The invalidate bit reads back as 1 until the sweep has finished and then clears itself. The sweep waits while the cache is active or unpowered. When the enable bit is cleared, the cache-active status stays high for a fixed drain time, so that lookups already in flight can complete.

A typical bring-up is: select both manual modes, request power, poll power status, optionally invalidate, then enable. Enabling straight after power-up, with no sweep, is allowed.

Top module: `cache_pwr_inv_ctrl`

## Requirements
- R1: After reset, both registers read 0 and `pwr_req_o`, `inv_clr_o` and `cache_active_o` are 0. The control register at address 0 uses this layout: bit 0 enable, bit 1 invalidate, bit 2 power request, bit 3 manual-invalidate mode, bit 4 manual-power mode. Bits 7:5 read 0.
- R2: `pwr_req_o` equals the power-request bit ANDed with the manual-power bit. Power status becomes 1 on the clock after `pwr_req_o` and `pwr_ack_i` are both high. It returns to 0 on the clock after either of them falls.
- R3: Writing 1 to the invalidate bit sets it only when the same write also sets manual-invalidate mode. A write of 0 to the invalidate bit does not clear it. The bit reads 1 until the sweep ends and then clears itself.
- R4: A sweep drives `inv_clr_o` high for exactly LINES consecutive clocks. `inv_idx_o` steps through 0 to LINES-1 in ascending order during those clocks. The invalidate bit reads 0 from the clock after the last strobe.
- R5: A sweep starts only when the cache is inactive and power status is 1. A request made while the cache is active or unpowered stays pending, reads as 1, and runs once both conditions hold.
- R6: The enable bit has no effect while power status is 0. The cache becomes active on the clock after enable and power status are both 1.
- R7: After enable or power status drops, `cache_active_o` stays 1 for exactly DRAIN clocks and then falls.
- R8: The status register at address 1 reads bit 0 = power status and bit 1 = cache active, with all other bits 0. Writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register (combinational) |
| pwr_req_o | output | 1 | Power request to the SRAM switch |
| pwr_ack_i | input | 1 | Power acknowledge from the SRAM switch |
| inv_clr_o | output | 1 | Valid-clear strobe to the tag RAM |
| inv_idx_o | output | IDX_W | Line index for the valid-clear strobe |
| cache_active_o | output | 1 | Cache is active, including the drain time |

## Verification
The hardest case to reach is an invalidation that is requested while the cache is still enabled. The request has to stay pending through the whole drain time and then run a complete sweep without any further write. To get there, the stimulus writes enable together with the invalidate bit, then clears enable with a write that leaves the invalidate bit at 0. The bench then checks that the bit still reads 1, that the clear strobes start only once the cache is inactive, and that each strobe carries the next index in ascending order. It also checks that the bit clears itself afterwards.

// File: rtl/cpi_pkg.sv
package cpi_pkg;

    // Control register layout, bit 4 down to bit 0.
    typedef struct packed {
        logic man_pwr;
        logic man_inv;
        logic pwr;
        logic inv;
        logic en;
    } cpi_ctrl_t;

    localparam int unsigned REG_W      = 8;
    localparam int unsigned CTRL_BITS  = 5;
    localparam logic        ADDR_CTRL  = 1'b0;
    localparam logic        ADDR_STAT  = 1'b1;

endpackage

// File: rtl/cpi_pwr_track.sv
module cpi_pwr_track (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic ack_i,
    output logic stat_o
);
    logic stat_d, stat_q;

    always_comb begin
        stat_d = req_i & ack_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q <= 1'b0;
        else         stat_q <= stat_d;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/cpi_sweep.sv
module cpi_sweep #(
    parameter int unsigned LINES = 8,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic             busy_o,
    output logic             clr_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
    } sweep_t;

    sweep_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy = 1'b1;
                s_d.idx  = '0;
            end
        end else if (s_q.idx == LAST) begin
            s_d.busy = 1'b0;
            s_d.idx  = '0;
        end else begin
            s_d.idx = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign clr_o  = s_q.busy;
    assign idx_o  = s_q.idx;
    assign done_o = s_q.busy && (s_q.idx == LAST);
endmodule

// File: rtl/cpi_drain.sv
module cpi_drain #(
    parameter int unsigned DRAIN = 4,
    localparam int unsigned CNT_W = $clog2(DRAIN + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic on_i,
    output logic active_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRAIN - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } drain_t;

    drain_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (on_i) begin
            d_d.active = 1'b1;
            d_d.cnt    = '0;
        end else if (d_q.active) begin
            if (d_q.cnt == CNT_LAST) begin
                d_d.active = 1'b0;
                d_d.cnt    = '0;
            end else begin
                d_d.cnt = d_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) d_q <= '0;
        else         d_q <= d_d;
    end

    assign active_o = d_q.active;
endmodule

// File: rtl/cache_pwr_inv_ctrl.sv
module cache_pwr_inv_ctrl
    import cpi_pkg::*;
#(
    parameter int unsigned LINES = 8,
    parameter int unsigned DRAIN = 4,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reg_we_i,
    input  logic             reg_addr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             pwr_req_o,
    input  logic             pwr_ack_i,
    output logic             inv_clr_o,
    output logic [IDX_W-1:0] inv_idx_o,
    output logic             cache_active_o
);
    cpi_ctrl_t ctrl_d, ctrl_q;
    logic      pwr_stat;
    logic      sweep_busy, sweep_done, sweep_start;
    logic      active;

    // Control register next value
    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_we_i && reg_addr_i == ADDR_CTRL) begin
            ctrl_d.man_pwr = reg_wdata_i[4];
            ctrl_d.man_inv = reg_wdata_i[3];
            ctrl_d.pwr     = reg_wdata_i[2];
            ctrl_d.en      = reg_wdata_i[0];
            ctrl_d.inv     = ctrl_q.inv | (reg_wdata_i[1] & reg_wdata_i[3]);
        end
        if (sweep_done) ctrl_d.inv = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '0;
        else         ctrl_q <= ctrl_d;
    end

    assign pwr_req_o   = ctrl_q.pwr & ctrl_q.man_pwr;
    assign sweep_start = ctrl_q.inv & ctrl_q.man_inv & pwr_stat & ~active & ~sweep_busy;

    cpi_pwr_track u_pwr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (pwr_req_o),
        .ack_i  (pwr_ack_i),
        .stat_o (pwr_stat)
    );

    cpi_sweep #(.LINES(LINES)) u_sweep (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (sweep_start),
        .busy_o  (sweep_busy),
        .clr_o   (inv_clr_o),
        .idx_o   (inv_idx_o),
        .done_o  (sweep_done)
    );

    cpi_drain #(.DRAIN(DRAIN)) u_drain (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .on_i     (ctrl_q.en & pwr_stat),
        .active_o (active)
    );

    assign cache_active_o = active;

    always_comb begin
        if (reg_addr_i == ADDR_STAT)
            reg_rdata_o = {6'b0, active, pwr_stat};
        else
            reg_rdata_o = {{(REG_W - CTRL_BITS){1'b0}}, ctrl_q};
    end
endmodule

// File: rtl/cache_pwr_inv_ctrl_chk.sv
module cache_pwr_inv_ctrl_chk #(
    parameter int unsigned LINES = 8,
    parameter int unsigned IDX_W = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pwr_req_o,
    input logic             pwr_ack_i,
    input logic             pwr_stat,
    input logic             en,
    input logic             inv,
    input logic             inv_clr_o,
    input logic [IDX_W-1:0] inv_idx_o,
    input logic             cache_active_o
);
    AST_STAT_FOLLOWS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_stat |-> $past(pwr_req_o && pwr_ack_i)); // R2

    AST_CLR_WHILE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inv_clr_o |-> (!cache_active_o && pwr_stat)); // R5

    AST_IDX_ASCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inv_clr_o && $past(inv_clr_o)) |-> (inv_idx_o == $past(inv_idx_o) + 1'b1)); // R4

    AST_SWEEP_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(inv_clr_o) |-> (inv_idx_o == '0)); // R4

    AST_INV_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(inv) |-> ($past(inv_clr_o) && $past(inv_idx_o) == IDX_W'(LINES - 1))); // R3

    AST_ACTIVE_NEEDS_POWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cache_active_o) |-> $past(pwr_stat && en)); // R6
endmodule

bind cache_pwr_inv_ctrl cache_pwr_inv_ctrl_chk #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pwr_req_o      (pwr_req_o),
    .pwr_ack_i      (pwr_ack_i),
    .pwr_stat       (pwr_stat),
    .en             (ctrl_q.en),
    .inv            (ctrl_q.inv),
    .inv_clr_o      (inv_clr_o),
    .inv_idx_o      (inv_idx_o),
    .cache_active_o (cache_active_o)
);

// File: tb/cache_pwr_inv_ctrl_tb_top.sv
module cache_pwr_inv_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 8;
    localparam int DRAIN = 4;
    localparam int IDX_W = 3;
    localparam int NVEC  = 11;

    // {write data, wait cycles, expected control, expected status}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h18, 8'd2,  8'h18, 8'h00},  // modes only
        {8'h1C, 8'd10, 8'h1C, 8'h01},  // power up
        {8'h1E, 8'd14, 8'h1C, 8'h01},  // sweep, self clear
        {8'h1D, 8'd3,  8'h1D, 8'h03},  // enable
        {8'h1C, 8'd8,  8'h1C, 8'h01},  // disable
        {8'h18, 8'd5,  8'h18, 8'h00},  // power down
        {8'h19, 8'd6,  8'h19, 8'h00},  // enable ignored unpowered
        {8'h1D, 8'd10, 8'h1D, 8'h03},  // power up and enable, no sweep
        {8'h1F, 8'd14, 8'h1F, 8'h03},  // invalidate pending while active
        {8'h1C, 8'd22, 8'h1C, 8'h01},  // drain, then pending sweep runs
        {8'h06, 8'd10, 8'h04, 8'h00}   // no manual modes: no power, no inv
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             we = 1'b0;
    logic             addr = 1'b0;
    logic [7:0]       wdata = '0;
    logic [7:0]       rdata;
    logic             pwr_req, pwr_ack;
    logic             clr;
    logic [IDX_W-1:0] idx;
    logic             active;
    logic [2:0]       ack_sh;

    int compared = 0;
    int mismatched = 0;
    int strobes = 0;
    int exp_idx = 0;
    logic prev_clr = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Power switch model: acknowledge three clocks after the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_sh <= '0;
        else        ack_sh <= {ack_sh[1:0], pwr_req};
    end
    assign pwr_ack = ack_sh[2] & pwr_req;

    cache_pwr_inv_ctrl #(.LINES(LINES), .DRAIN(DRAIN)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .reg_we_i       (we),
        .reg_addr_i     (addr),
        .reg_wdata_i    (wdata),
        .reg_rdata_o    (rdata),
        .pwr_req_o      (pwr_req),
        .pwr_ack_i      (pwr_ack),
        .inv_clr_o      (clr),
        .inv_idx_o      (idx),
        .cache_active_o (active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = 1'b0; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Sweep monitor: R4 index order, strobe counting
    always @(negedge clk) begin
        if (rst_n && clr) begin
            if (!prev_clr) exp_idx = 0;
            check("R4 sweep index", 32'(idx), 32'(exp_idx));
            exp_idx++;
            strobes++;
        end
        prev_clr = clr;
    end

    initial begin
        logic [7:0] v;
        int s0;
        repeat (3) @(negedge clk);
        // R1 / R8 reset state
        rd(1'b0, v); check("R1 reset control", 32'(v), 32'h0);
        rd(1'b1, v); check("R8 reset status", 32'(v), 32'h0);
        check("R1 reset outputs", {29'b0, pwr_req, clr, active}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][31:24]);
            repeat (int'(VEC[i][23:16])) @(negedge clk);
            rd(1'b0, v); check($sformatf("R1 R3 R5 R6 vec %0d control", i), 32'(v), 32'(VEC[i][15:8]));
            rd(1'b1, v); check($sformatf("R2 R6 R7 R8 vec %0d status", i), 32'(v), 32'(VEC[i][7:0]));
        end

        // R2: no power status before acknowledge; request gated by mode
        check("R2 req gated without manual-power", 32'(pwr_req), 32'h0);
        wr(8'h1C);
        check("R2 request raised", 32'(pwr_req), 32'h1);
        rd(1'b1, v); check("R2 status before ack", 32'(v), 32'h0);
        repeat (6) @(negedge clk);
        rd(1'b1, v); check("R2 status after ack", 32'(v), 32'h1);

        // R8: writes to status address ignored
        @(negedge clk); we = 1'b1; addr = 1'b1; wdata = 8'h00;
        @(negedge clk); we = 1'b0;
        rd(1'b0, v); check("R8 status write ignored, control", 32'(v), 32'h1C);
        rd(1'b1, v); check("R8 status write ignored, status", 32'(v), 32'h1);

        // R4: strobe count of one sweep
        s0 = strobes;
        wr(8'h1E);
        repeat (LINES + 4) @(negedge clk);
        check("R4 strobe count", 32'(strobes - s0), 32'(LINES));
        rd(1'b0, v); check("R3 inv self clear", 32'(v), 32'h1C);

        // R7: exact drain length
        wr(8'h1D);
        repeat (2) @(negedge clk);
        check("R6 active after enable", 32'(active), 32'h1);
        wr(8'h1C);
        repeat (DRAIN - 1) @(posedge clk);
        @(negedge clk);
        check("R7 active during drain", 32'(active), 32'h1);
        @(posedge clk);
        @(negedge clk);
        check("R7 active after drain", 32'(active), 32'h0);

        // R3: invalidate write without manual-invalidate mode ignored
        s0 = strobes;
        wr(8'h16);
        repeat (LINES + 4) @(negedge clk);
        rd(1'b0, v); check("R3 inv ignored without mode", 32'(v), 32'h14);
        check("R3 no strobes without mode", 32'(strobes - s0), 32'h0);

        // R5: pending while unpowered
        wr(8'h08);
        repeat (4) @(negedge clk);
        s0 = strobes;
        wr(8'h0A);
        repeat (LINES + 4) @(negedge clk);
        rd(1'b0, v); check("R5 pending while unpowered", 32'(v), 32'h0A);
        check("R5 no strobes unpowered", 32'(strobes - s0), 32'h0);
        wr(8'h1C);
        repeat (LINES + 10) @(negedge clk);
        check("R5 pending sweep ran", 32'(strobes - s0), 32'(LINES));
        rd(1'b0, v); check("R5 pending cleared", 32'(v), 32'h1C);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule